// File: doc/BRIEF.md
# Physical Access Router with Alignment and Bound Checks

The router sits after address translation. It takes one physical access at a time: a word read, a word write, a byte read or a byte write. It checks the access and then sends it either to a synchronous RAM port or to a memory-mapped device port. A request is accepted with a valid/ready handshake. The block answers with a single response pulse. That pulse carries the read data, an error flag and an exception code.

Checks run in a fixed order. First comes word alignment. Next comes the device window, which includes both of its ends. The RAM size bound comes last. An access that fails a check never reaches either port. The error code depends on the direction of the access: reads report a load address error and writes report a store address error. For byte accesses to RAM, the lane is picked after an optional big-endian flip of the two low address bits. The device port always sees the address exactly as requested.

Top module: `phys_access_router`

## Requirements
- R1: `req_ready_o` is high after reset and whenever the block is idle. It drops in the cycle after a request is accepted. Every accepted request produces exactly one single-cycle `rsp_valid_o`, and `req_ready_o` is high again in the cycle after that pulse.
- R2: A word access (`req_op_i[1]`=0) with a nonzero `req_addr_i[1:0]` responds with `rsp_err_o`=1. The code is `rsp_exc_o`=4 for a read (`req_op_i[0]`=0) and 5 for a write. Neither port is touched.
- R3: An address in [DEV_BASE, DEV_TOP], both ends included, asserts `dev_req_o` with `dev_addr_o` equal to the requested address and never asserts `ram_req_o`. A device read returns `dev_rdata_i` for a word, or its low byte zero-extended for a byte. A device byte write places the byte in `dev_wdata_o[7:0]`, zeroes the upper bits of `dev_wdata_o` and sets `dev_byte_o`=1.
- R4: An access that passes alignment, lies outside the device window and has an address of RAM_BYTES or above faults with code 4 on a read and 5 on a write. No RAM access is made. The last byte, at RAM_BYTES-1, is still served.
- R5: Byte accesses (`req_op_i[1]`=1) never raise an alignment fault, whatever their low address bits are.
- R6: With BIG_ENDIAN=1, a byte access to RAM uses lane `addr[1:0]^3`. Lane n is bits 8n+7..8n of the RAM word at `ram_addr_o` = `addr[..:2]`.
- R7: With BIG_ENDIAN=0, a byte access to RAM uses lane `addr[1:0]` unchanged.
- R8: Device-window membership is decided on the address before any endian flip. A byte access just outside the window is not routed to the device even if the flipped address would fall inside it. An in-window byte access reaches `dev_addr_o` unflipped.
- R9: A byte read returns the selected byte zero-extended to 32 bits. A byte write enables exactly one lane in `ram_be_o`, so the other three bytes of the word keep their contents.
- R10: A word write stores all four lanes (`ram_be_o`=4'hF). A later word read of the same address returns the written value. Responses to writes and to faults carry `rsp_rdata_o`=0.
- R11: The alignment check comes before the window check, so a misaligned word access inside the device window faults and does not reach the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request accepted on valid&ready |
| req_op_i | input | 2 | bit0 write, bit1 byte access |
| req_addr_i | input | 32 | Physical address |
| req_wdata_i | input | 32 | Write data (byte writes use bits 7..0) |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Address error |
| rsp_exc_o | output | 5 | Exception code: 0 none, 4 load address error, 5 store address error |
| rsp_rdata_o | output | 32 | Read data |
| ram_req_o | output | 1 | RAM access strobe |
| ram_we_o | output | 1 | RAM write |
| ram_addr_o | output | RAM_WAW | RAM word index |
| ram_be_o | output | 4 | RAM byte-lane enables |
| ram_wdata_o | output | 32 | RAM write data |
| ram_rdata_i | input | 32 | RAM read data, valid the cycle after ram_req_o |
| dev_req_o | output | 1 | Device request, held until acknowledged |
| dev_we_o | output | 1 | Device write |
| dev_byte_o | output | 1 | Device byte access |
| dev_addr_o | output | 32 | Device address, unmodified |
| dev_wdata_o | output | 32 | Device write data |
| dev_rdata_i | input | 32 | Device read data, sampled with dev_ack_i |
| dev_ack_i | input | 1 | Device completion |

## Verification
Several checks can apply to the same request, and precedence decides the outcome. The bench provokes these cases deliberately. In one, a misaligned word address lies inside the device window, and the alignment fault must win with no device strobe. In the other, a byte address sits one below an unaligned window base, so the endian flip would move it into the window, but the unflipped address must be routed to the RAM bound check and fault. Two instances with opposite endianness run the same stimulus. A behavioural byte-array model predicts every response, and a per-clock monitor flags any port strobe outside the route the model expects.

// File: rtl/par_pkg.sv
package par_pkg;
  typedef enum logic [1:0] {
    RT_FAULT = 2'd0,
    RT_RAM   = 2'd1,
    RT_DEV   = 2'd2
  } route_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RAM    = 3'd1,
    S_RAM_RD = 3'd2,
    S_DEV    = 3'd3,
    S_RESP   = 3'd4
  } state_e;

  localparam logic [4:0] EXC_NONE    = 5'd0;
  localparam logic [4:0] EXC_LD_ADDR = 5'd4;
  localparam logic [4:0] EXC_ST_ADDR = 5'd5;
endpackage

// File: rtl/par_classify.sv
module par_classify
  import par_pkg::*;
#(
  parameter logic [31:0] DEV_BASE  = 32'h1000_0000,
  parameter logic [31:0] DEV_TOP   = 32'h1000_0FFF,
  parameter int unsigned RAM_BYTES = 65536
) (
  input  logic [1:0]  op_i,
  input  logic [31:0] addr_i,
  output route_e      route_o,
  output logic [4:0]  exc_o
);
  localparam logic [32:0] RAM_LIMIT = 33'(RAM_BYTES);

  logic is_wr, misalign, in_win, over;

  always_comb begin
    is_wr    = op_i[0];
    misalign = !op_i[1] && (addr_i[1:0] != 2'b00);
    in_win   = (addr_i >= DEV_BASE) && (addr_i <= DEV_TOP);
    over     = {1'b0, addr_i} >= RAM_LIMIT;
    // order matters: alignment, then window, then RAM bound
    if (misalign)    route_o = RT_FAULT;
    else if (in_win) route_o = RT_DEV;
    else if (over)   route_o = RT_FAULT;
    else             route_o = RT_RAM;
    if (route_o == RT_FAULT) exc_o = is_wr ? EXC_ST_ADDR : EXC_LD_ADDR;
    else                     exc_o = EXC_NONE;
  end
endmodule

// File: rtl/par_lane.sv
module par_lane #(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic        byte_i,
  input  logic [1:0]  addr_lo_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] rdata_i,
  output logic [3:0]  be_o,
  output logic [31:0] wdata_o,
  output logic [31:0] rdata_o
);
  logic [1:0] lane;
  logic [7:0] rbyte;

  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane = addr_lo_i ^ 2'b11;
    end else begin : g_little
      assign lane = addr_lo_i;
    end
  endgenerate

  always_comb begin
    case (lane)
      2'd0:    rbyte = rdata_i[7:0];
      2'd1:    rbyte = rdata_i[15:8];
      2'd2:    rbyte = rdata_i[23:16];
      default: rbyte = rdata_i[31:24];
    endcase
    be_o    = byte_i ? (4'b0001 << lane) : 4'hF;
    wdata_o = byte_i ? {4{wdata_i[7:0]}} : wdata_i;
    rdata_o = byte_i ? {24'b0, rbyte} : rdata_i;
  end
endmodule

// File: rtl/par_ctrl.sv
module par_ctrl
  import par_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [1:0]  req_op_i,
  input  logic [31:0] req_addr_i,
  input  logic [31:0] req_wdata_i,
  input  route_e      route_i,
  input  logic [4:0]  exc_i,
  input  logic [31:0] ram_rd_i,
  input  logic [31:0] dev_rd_i,
  input  logic        dev_ack_i,
  output logic        ready_o,
  output logic        ram_req_o,
  output logic        dev_req_o,
  output logic        rsp_valid_o,
  output logic        rsp_err_o,
  output logic [4:0]  rsp_exc_o,
  output logic [31:0] rsp_rdata_o,
  output logic [1:0]  op_q_o,
  output logic [31:0] addr_q_o,
  output logic [31:0] wdata_q_o
);
  state_e      st_q;
  logic [1:0]  op_q;
  logic [31:0] addr_q, wdata_q, rdata_q;
  logic [4:0]  exc_q;
  logic        err_q;
  logic        fire;

  assign fire = req_valid_i && (st_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= 2'b00;
      addr_q  <= 32'b0;
      wdata_q <= 32'b0;
      rdata_q <= 32'b0;
      exc_q   <= EXC_NONE;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (fire) begin
          op_q    <= req_op_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          exc_q   <= exc_i;
          err_q   <= (route_i == RT_FAULT);
          rdata_q <= 32'b0;
          case (route_i)
            RT_RAM:  st_q <= S_RAM;
            RT_DEV:  st_q <= S_DEV;
            default: st_q <= S_RESP;
          endcase
        end
        S_RAM:    st_q <= op_q[0] ? S_RESP : S_RAM_RD;
        S_RAM_RD: begin
          rdata_q <= ram_rd_i;
          st_q    <= S_RESP;
        end
        S_DEV: if (dev_ack_i) begin
          if (!op_q[0]) rdata_q <= dev_rd_i;
          st_q <= S_RESP;
        end
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o     = (st_q == S_IDLE);
  assign ram_req_o   = (st_q == S_RAM);
  assign dev_req_o   = (st_q == S_DEV);
  assign rsp_valid_o = (st_q == S_RESP);
  assign rsp_err_o   = err_q;
  assign rsp_exc_o   = exc_q;
  assign rsp_rdata_o = rdata_q;
  assign op_q_o      = op_q;
  assign addr_q_o    = addr_q;
  assign wdata_q_o   = wdata_q;

  // R1
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && ready_o));
  // R1
  accept_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !ready_o);
endmodule

// File: rtl/phys_access_router.sv
module phys_access_router
  import par_pkg::*;
#(
  parameter logic [31:0] DEV_BASE   = 32'h1000_0000,
  parameter logic [31:0] DEV_TOP    = 32'h1000_0FFF,
  parameter int unsigned RAM_BYTES  = 65536,
  parameter bit          BIG_ENDIAN = 1'b1,
  localparam int unsigned RAM_WAW   = $clog2(RAM_BYTES / 4)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [1:0]         req_op_i,
  input  logic [31:0]        req_addr_i,
  input  logic [31:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [4:0]         rsp_exc_o,
  output logic [31:0]        rsp_rdata_o,
  output logic               ram_req_o,
  output logic               ram_we_o,
  output logic [RAM_WAW-1:0] ram_addr_o,
  output logic [3:0]         ram_be_o,
  output logic [31:0]        ram_wdata_o,
  input  logic [31:0]        ram_rdata_i,
  output logic               dev_req_o,
  output logic               dev_we_o,
  output logic               dev_byte_o,
  output logic [31:0]        dev_addr_o,
  output logic [31:0]        dev_wdata_o,
  input  logic [31:0]        dev_rdata_i,
  input  logic               dev_ack_i
);
  route_e      route;
  logic [4:0]  exc;
  logic [1:0]  op_q;
  logic [31:0] addr_q, wdata_q, ram_rd, dev_rd;

  par_classify #(
    .DEV_BASE (DEV_BASE),
    .DEV_TOP  (DEV_TOP),
    .RAM_BYTES(RAM_BYTES)
  ) u_classify (
    .op_i   (req_op_i),
    .addr_i (req_addr_i),
    .route_o(route),
    .exc_o  (exc)
  );

  par_lane #(.BIG_ENDIAN(BIG_ENDIAN)) u_lane (
    .byte_i   (op_q[1]),
    .addr_lo_i(addr_q[1:0]),
    .wdata_i  (wdata_q),
    .rdata_i  (ram_rdata_i),
    .be_o     (ram_be_o),
    .wdata_o  (ram_wdata_o),
    .rdata_o  (ram_rd)
  );

  par_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_op_i   (req_op_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .route_i    (route),
    .exc_i      (exc),
    .ram_rd_i   (ram_rd),
    .dev_rd_i   (dev_rd),
    .dev_ack_i  (dev_ack_i),
    .ready_o    (req_ready_o),
    .ram_req_o  (ram_req_o),
    .dev_req_o  (dev_req_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_err_o  (rsp_err_o),
    .rsp_exc_o  (rsp_exc_o),
    .rsp_rdata_o(rsp_rdata_o),
    .op_q_o     (op_q),
    .addr_q_o   (addr_q),
    .wdata_q_o  (wdata_q)
  );

  assign ram_we_o    = op_q[0];
  assign ram_addr_o  = addr_q[RAM_WAW+1:2];
  assign dev_we_o    = op_q[0];
  assign dev_byte_o  = op_q[1];
  assign dev_addr_o  = addr_q;
  assign dev_wdata_o = op_q[1] ? {24'b0, wdata_q[7:0]} : wdata_q;
  assign dev_rd      = op_q[1] ? {24'b0, dev_rdata_i[7:0]} : dev_rdata_i;

  // R2
  misalign_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_op_i[1] && (req_addr_i[1:0] != 2'b00))
    |=> (rsp_valid_o && rsp_err_o));
  // R3
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o |-> !ram_req_o);
  // R4
  bound_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (req_op_i[1] || (req_addr_i[1:0] == 2'b00)) &&
     (req_addr_i < DEV_BASE || req_addr_i > DEV_TOP) &&
     ({1'b0, req_addr_i} >= 33'(RAM_BYTES)))
    |=> (rsp_valid_o && rsp_err_o && rsp_exc_o == (req_op_i[0] ? 5'd5 : 5'd4)));
  // R9
  lane_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_req_o && ram_we_o) |-> ($countones(ram_be_o) == 1 || ram_be_o == 4'hF));
  // R2
  fault_no_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (!$past(ram_req_o) && !$past(dev_req_o)));
endmodule

// File: tb/phys_access_router_tb.sv
module tb_ram #(parameter int WORDS = 256, parameter int AW = 8) (
  input  logic          clk,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];
  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 32'b0;
    rdata = 32'b0;
  end
  always @(posedge clk) begin
    if (req) begin
      rdata <= mem[addr];
      if (we) for (int i = 0; i < 4; i++) if (be[i]) mem[addr][8*i +: 8] <= wdata[8*i +: 8];
    end
  end
endmodule

module tb_dev (
  input  logic        clk,
  input  logic        req,
  input  logic        we,
  input  logic        bytem,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ack,
  output logic [31:0] last_addr,
  output logic [31:0] last_wdata,
  output logic        last_byte
);
  int cnt;
  initial begin
    cnt = 0; ack = 0; rdata = 0; last_addr = 0; last_wdata = 0; last_byte = 0;
  end
  always @(posedge clk) begin
    if (ack) begin
      ack <= 1'b0;
      cnt <= 0;
    end else if (req) begin
      if (cnt == 2) begin
        ack        <= 1'b1;
        rdata      <= {addr[15:0], ~addr[15:0]};
        last_addr  <= addr;
        last_byte  <= bytem;
        last_wdata <= we ? wdata : 32'hDEAD_BEEF;
      end else cnt <= cnt + 1;
    end
  end
endmodule

module phys_access_router_tb;
  localparam logic [31:0] DB = 32'h0000_8001;
  localparam logic [31:0] DT = 32'h0000_80FE;
  localparam int RB = 1024;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_addr = 32'b0, req_wdata = 32'b0;

  logic        rdy_b, rv_b, err_b, rreq_b, rwe_b, dreq_b, dwe_b, dby_b, ack_b;
  logic [4:0]  exc_b;
  logic [31:0] rd_b, rwd_b, rrd_b, dadr_b, dwd_b, drd_b, la_b, lw_b;
  logic [AW-1:0] radr_b;
  logic [3:0]  rbe_b;
  logic        lby_b;

  logic        rdy_l, rv_l, err_l, rreq_l, rwe_l, dreq_l, dwe_l, dby_l, ack_l;
  logic [4:0]  exc_l;
  logic [31:0] rd_l, rwd_l, rrd_l, dadr_l, dwd_l, drd_l, la_l, lw_l;
  logic [AW-1:0] radr_l;
  logic [3:0]  rbe_l;
  logic        lby_l;

  phys_access_router #(.DEV_BASE(DB), .DEV_TOP(DT), .RAM_BYTES(RB), .BIG_ENDIAN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy_b),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rv_b), .rsp_err_o(err_b), .rsp_exc_o(exc_b), .rsp_rdata_o(rd_b),
    .ram_req_o(rreq_b), .ram_we_o(rwe_b), .ram_addr_o(radr_b), .ram_be_o(rbe_b),
    .ram_wdata_o(rwd_b), .ram_rdata_i(rrd_b),
    .dev_req_o(dreq_b), .dev_we_o(dwe_b), .dev_byte_o(dby_b), .dev_addr_o(dadr_b),
    .dev_wdata_o(dwd_b), .dev_rdata_i(drd_b), .dev_ack_i(ack_b));
  tb_ram #(.WORDS(RB/4), .AW(AW)) u_ram_b (.clk(clk), .req(rreq_b), .we(rwe_b),
    .addr(radr_b), .be(rbe_b), .wdata(rwd_b), .rdata(rrd_b));
  tb_dev u_dev_b (.clk(clk), .req(dreq_b), .we(dwe_b), .bytem(dby_b), .addr(dadr_b),
    .wdata(dwd_b), .rdata(drd_b), .ack(ack_b), .last_addr(la_b), .last_wdata(lw_b),
    .last_byte(lby_b));

  phys_access_router #(.DEV_BASE(DB), .DEV_TOP(DT), .RAM_BYTES(RB), .BIG_ENDIAN(1'b0)) u_dut_le (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy_l),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rv_l), .rsp_err_o(err_l), .rsp_exc_o(exc_l), .rsp_rdata_o(rd_l),
    .ram_req_o(rreq_l), .ram_we_o(rwe_l), .ram_addr_o(radr_l), .ram_be_o(rbe_l),
    .ram_wdata_o(rwd_l), .ram_rdata_i(rrd_l),
    .dev_req_o(dreq_l), .dev_we_o(dwe_l), .dev_byte_o(dby_l), .dev_addr_o(dadr_l),
    .dev_wdata_o(dwd_l), .dev_rdata_i(drd_l), .dev_ack_i(ack_l));
  tb_ram #(.WORDS(RB/4), .AW(AW)) u_ram_l (.clk(clk), .req(rreq_l), .we(rwe_l),
    .addr(radr_l), .be(rbe_l), .wdata(rwd_l), .rdata(rrd_l));
  tb_dev u_dev_l (.clk(clk), .req(dreq_l), .we(dwe_l), .bytem(dby_l), .addr(dadr_l),
    .wdata(dwd_l), .rdata(drd_l), .ack(ack_l), .last_addr(la_l), .last_wdata(lw_l),
    .last_byte(lby_l));

  int checks = 0, errors = 0, cyc = 0;
  int cur_route = 0; // 0 idle, 1 ram, 2 dev, 3 fault
  string cur_tag = "";
  logic [7:0] ref_mem [2][RB]; // [0] big, [1] little

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
        finish_run();
      end
    end
  end

  // per-clock route monitor (R2 R3 R4 R8 R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if ((rreq_b || rreq_l) && cur_route != 1) begin
        errors++;
        $display("FAIL %s: actual RAM strobe expected route %0d", cur_tag, cur_route);
      end
      if ((dreq_b || dreq_l) && cur_route != 2) begin
        errors++;
        $display("FAIL %s: actual device strobe expected route %0d", cur_tag, cur_route);
      end
    end
  end

  function automatic logic [31:0] ref_word(input int e, input logic [31:0] a);
    int b;
    b = int'(a[9:0]) & ~3;
    return {ref_mem[e][b+3], ref_mem[e][b+2], ref_mem[e][b+1], ref_mem[e][b]};
  endfunction

  task automatic run(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                     input string tag);
    bit is_wr, is_byte;
    int route, n, idx;
    logic [4:0] xexc;
    logic [31:0] xrd [2];
    logic [31:0] dval;
    is_wr = op[0];
    is_byte = op[1];
    dval = {addr[15:0], ~addr[15:0]};
    if (!is_byte && addr[1:0] != 2'b00)              route = 3;
    else if (addr >= DB && addr <= DT)               route = 2;
    else if (addr >= 32'(RB))                        route = 3;
    else                                             route = 1;
    xexc = (route == 3) ? (is_wr ? 5'd5 : 5'd4) : 5'd0;
    for (int e = 0; e < 2; e++) begin
      xrd[e] = 32'b0;
      if (!is_wr && route == 2) xrd[e] = is_byte ? {24'b0, dval[7:0]} : dval;
      if (!is_wr && route == 1) begin
        if (is_byte) begin
          idx = int'(addr[9:0] ^ ((e == 0) ? 10'd3 : 10'd0));
          xrd[e] = {24'b0, ref_mem[e][idx]};
        end else xrd[e] = ref_word(e, addr);
      end
    end
    cur_route = route;
    cur_tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    while (!rdy_b) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rdy_b && !rdy_l, {tag, " R1 ready low after accept"}, {31'b0, rdy_b}, 32'h0);
    n = 0;
    while (!rv_b && n < 50) begin @(negedge clk); n++; end
    chk(rv_b && rv_l, {tag, " response arrives"}, {31'b0, rv_b & rv_l}, 32'h1);
    chk(err_b == (route == 3) && err_l == (route == 3), {tag, " err"},
        {31'b0, err_b}, {31'b0, route == 3});
    chk(exc_b == xexc && exc_l == xexc, {tag, " exc"}, {27'b0, exc_b}, {27'b0, xexc});
    chk(rd_b == xrd[0], {tag, " rdata big"}, rd_b, xrd[0]);
    chk(rd_l == xrd[1], {tag, " rdata little"}, rd_l, xrd[1]);
    if (route == 2) begin
      chk(la_b == addr && la_l == addr, {tag, " R3 R8 device addr"}, la_b, addr);
      chk(lby_b == is_byte, {tag, " R3 device byte flag"}, {31'b0, lby_b}, {31'b0, is_byte});
      if (is_wr) chk(lw_b == (is_byte ? {24'b0, wd[7:0]} : wd), {tag, " R3 device wdata"},
                     lw_b, is_byte ? {24'b0, wd[7:0]} : wd);
    end
    if (route == 1 && is_wr) begin
      for (int e = 0; e < 2; e++) begin
        if (is_byte) ref_mem[e][int'(addr[9:0] ^ ((e == 0) ? 10'd3 : 10'd0))] = wd[7:0];
        else for (int i = 0; i < 4; i++) ref_mem[e][int'(addr[9:0]) + i] = wd[8*i +: 8];
      end
    end
    @(negedge clk);
    chk(rdy_b && rdy_l && !rv_b && !rv_l, {tag, " R1 idle after response"},
        {30'b0, rdy_b, rv_b}, 32'h2);
    cur_route = 0;
  endtask

  initial begin
    for (int e = 0; e < 2; e++) for (int i = 0; i < RB; i++) ref_mem[e][i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rdy_b && rdy_l && !rv_b && !rreq_b && !dreq_b, "R1 reset state",
        {28'b0, rdy_b, rv_b, rreq_b, dreq_b}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 word round trip
    run(2'b01, 32'h0000_0010, 32'h1122_3344, "R10 word write");
    run(2'b00, 32'h0000_0010, 32'h0, "R10 word read");
    // R6 R7 R9 byte read lanes
    run(2'b10, 32'h0000_0010, 32'h0, "R6 R7 byte read lane0");
    run(2'b10, 32'h0000_0012, 32'h0, "R6 R7 byte read lane2");
    // R9 byte write touches one byte
    run(2'b11, 32'h0000_0011, 32'hFFFF_FFAB, "R9 byte write");
    run(2'b00, 32'h0000_0010, 32'h0, "R9 word after byte write");
    // R5 odd byte addresses
    run(2'b11, 32'h0000_0023, 32'h0000_005C, "R5 odd byte write");
    run(2'b10, 32'h0000_0021, 32'h0, "R5 odd byte read");
    run(2'b00, 32'h0000_0020, 32'h0, "R5 word view");
    // R4 bound
    run(2'b11, 32'h0000_03FF, 32'h0000_0077, "R4 last byte write");
    run(2'b01, 32'h0000_03F8, 32'hCAFE_F00D, "R4 word below top");
    run(2'b00, 32'h0000_03FC, 32'h0, "R4 top word read");
    run(2'b00, 32'h0000_0400, 32'h0, "R4 word read at limit");
    run(2'b01, 32'h0000_0400, 32'h1, "R4 word write at limit");
    run(2'b10, 32'h0000_0400, 32'h0, "R4 byte read at limit");
    run(2'b11, 32'h0000_07FF, 32'h2, "R4 byte write above");
    // R2 misaligned words
    run(2'b00, 32'h0000_0012, 32'h0, "R2 word read misaligned");
    run(2'b01, 32'h0000_0011, 32'h3, "R2 word write misaligned");
    run(2'b00, 32'h0000_0010, 32'h0, "R2 memory untouched");
    // R3 device window
    run(2'b00, 32'h0000_8004, 32'h0, "R3 device word read");
    run(2'b01, 32'h0000_80FC, 32'h89AB_CDEF, "R3 device word write");
    run(2'b10, 32'h0000_8001, 32'h0, "R3 R8 byte read at base");
    run(2'b11, 32'h0000_80FE, 32'h0000_1234, "R3 byte write at top");
    // R8 window before flip
    run(2'b10, 32'h0000_8000, 32'h0, "R8 byte below base");
    run(2'b11, 32'h0000_80FF, 32'h5, "R8 byte above top");
    // R11 alignment before window
    run(2'b00, 32'h0000_8002, 32'h0, "R11 misaligned in window read");
    run(2'b01, 32'h0000_8005, 32'h6, "R11 misaligned in window write");
    finish_run();
  end
endmodule